// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block is the controller half of a device programmer for a byte-wide UV-erasable EPROM. Once started, it reads each intended byte from a source memory and works through the target's addresses in ascending order. For every byte that is not FFh, it applies a fixed-width program pulse and then reads the same location back after a short settle delay. If the readback does not match, it pulses again. An address gets only the pulses it needs, up to a bounded limit.

During this per-address loop the block asks the external supply hardware for the programming voltage and for the raised core supply. When the last address is done, it drops both requests and asks for the nominal-supply verify condition instead. It then reads every location once more and compares each one with the source.

The run ends in one of two ways. If every address checks out, `done` is raised. If an address uses up its pulses, or any location mismatches in the final pass, `fail` is raised and the address is latched. A new `start` pulse begins a fresh run from address zero.

Top module: `eprom_burn_seq`

## Requirements
- R1: While reset is asserted and after its release, the sequencer sits idle. All three target strobes (`tgt_ce_n`, `tgt_oe_n`, `tgt_pgm_n`) are high, `tgt_dq_oe`, `vpp_req`, `vcc_hi_req` and `nom_chk_req` are low, and `done` and `fail` are low.
- R2: A program pulse holds `tgt_pgm_n` low for exactly `CLK_HZ/1_000_000*PULSE_US` cycles. Throughout the pulse, `tgt_ce_n` is low, `tgt_oe_n` is high and `tgt_dq_oe` is high. `tgt_dout` carries the source byte and `tgt_addr` does not change.
- R3: Each pulse is followed by a readback window of exactly `SETTLE_CYC` cycles. During the window `tgt_ce_n` and `tgt_oe_n` are low, `tgt_pgm_n` is high and the data bus is released. `tgt_din` is compared on the window's last cycle.
- R4: On a readback mismatch another pulse is issued. An address therefore receives exactly as many pulses as the target needs, and a match after the `MAX_PULSES`-th pulse still counts as success.
- R5: If the readback still mismatches after `MAX_PULSES` pulses, `fail` goes high and `fail_addr` holds that address. No further strobe activity follows.
- R6: Addresses are programmed in ascending order, from 0 to 2^`ADDR_W`-1.
- R7: During every pulse and every programming-phase readback, `vpp_req` and `vcc_hi_req` are high and `nom_chk_req` is low. During the final verify pass, `nom_chk_req` is high and the other two requests are low.
- R8: An address whose source byte is FFh receives no pulse.
- R9: After the last address, every location is read once in ascending order, each in its own R3-shaped window under the nominal condition. The first mismatch sets `fail` with that address in `fail_addr`.
- R10: `done` goes high only when the whole final pass matches, and `done` and `fail` are never high together. A `start` pulse from the done or fail state begins a new run at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| src_addr | output | ADDR_W | Source memory read address |
| src_data | input | DATA_W | Source byte, valid one cycle after `src_addr` |
| tgt_addr | output | ADDR_W | Target address bus |
| tgt_dout | output | DATA_W | Byte driven onto the target data bus |
| tgt_dq_oe | output | 1 | High while the sequencer drives the data bus |
| tgt_din | input | DATA_W | Byte read from the target data bus |
| tgt_ce_n | output | 1 | Target chip enable, active low |
| tgt_oe_n | output | 1 | Target output enable, active low |
| tgt_pgm_n | output | 1 | Target program strobe, active low |
| vpp_req | output | 1 | Request for the programming voltage |
| vcc_hi_req | output | 1 | Request for the raised core supply |
| nom_chk_req | output | 1 | Request for nominal supplies during the final verify pass |
| done | output | 1 | Run finished with all locations verified |
| fail | output | 1 | Run stopped on an error |
| fail_addr | output | ADDR_W | Address that caused `fail` |

## Verification
The bench runs the sequencer against a behavioural target whose cells only take their data after a per-address number of pulses. It drives several image patterns:
- A mixed image with FFh gaps and one to three pulses per address shows the retry count and the skip rule.
- An all-FFh image shows a run with no pulses at all.
- An image where one address needs exactly the pulse limit separates a correct boundary from an off-by-one.
- An address that never takes its data, and a location that reads back wrong only under nominal supplies, show the two failure paths and that `fail_addr` points at the right place.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  // Sequencer phases: programming loop (P*), final verify (V*), terminal states
  typedef enum logic [3:0] {
    S_IDLE,
    S_PFETCH,
    S_PLOAD,
    S_PULSE,
    S_PSETTLE,
    S_VFETCH,
    S_VLOAD,
    S_VSETTLE,
    S_DONE,
    S_FAIL
  } seq_state_e;

endpackage

// File: rtl/seq_timer.sv
// Down-counting interval timer shared by pulse width and settle delay.
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/addr_walker.sv
// Ascending address counter with a last-location flag.
module addr_walker #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = clr || step;
    addr_d  = clr ? '0 : (addr_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == {AW{1'b1}});

endmodule

// File: rtl/pulse_tally.sv
// Counts pulses given to the current address; flags when the budget is used.
module pulse_tally #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic spent
);

  localparam int CW = (MAX_PULSES < 2) ? 1 : $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || bump;
    cnt_d  = clr ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign spent = (cnt_q == CW'(MAX_PULSES));

  // R5
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PULSES));

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_dout,
  output logic              tgt_dq_oe,
  input  logic [DATA_W-1:0] tgt_din,
  output logic              tgt_ce_n,
  output logic              tgt_oe_n,
  output logic              tgt_pgm_n,
  output logic              vpp_req,
  output logic              vcc_hi_req,
  output logic              nom_chk_req,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int TMAX      = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TW        = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

  seq_state_e st_q, st_d;
  logic [DATA_W-1:0] byte_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [ADDR_W-1:0] walk_addr;
  logic              at_last;
  logic              byte_ld, walk_clr, walk_step;
  logic              tal_clr, tal_bump, spent;
  logic              tm_load, tm_exp, fail_ld;
  logic [TW-1:0]     tm_val;
  logic              rd_match;

  seq_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  addr_walker #(.AW(ADDR_W)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (walk_clr),
    .step    (walk_step),
    .addr    (walk_addr),
    .at_last (at_last)
  );

  pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tal_clr),
    .bump  (tal_bump),
    .spent (spent)
  );

  assign rd_match = (tgt_din == byte_q);

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    byte_ld   = 1'b0;
    walk_clr  = 1'b0;
    walk_step = 1'b0;
    tal_clr   = 1'b0;
    tal_bump  = 1'b0;
    tm_load   = 1'b0;
    tm_val    = PULSE_LD;
    fail_ld   = 1'b0;
    case (st_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          walk_clr = 1'b1;
          st_d     = S_PFETCH;
        end
      end
      S_PFETCH: st_d = S_PLOAD;
      S_PLOAD: begin
        byte_ld = 1'b1;
        if (src_data == {DATA_W{1'b1}}) begin
          if (at_last) begin
            walk_clr = 1'b1;
            st_d     = S_VFETCH;
          end else begin
            walk_step = 1'b1;
            st_d      = S_PFETCH;
          end
        end else begin
          tal_clr = 1'b1;
          tm_load = 1'b1;
          tm_val  = PULSE_LD;
          st_d    = S_PULSE;
        end
      end
      S_PULSE: begin
        if (tm_exp) begin
          tal_bump = 1'b1;
          tm_load  = 1'b1;
          tm_val   = SETTLE_LD;
          st_d     = S_PSETTLE;
        end
      end
      S_PSETTLE: begin
        if (tm_exp) begin
          if (rd_match) begin
            if (at_last) begin
              walk_clr = 1'b1;
              st_d     = S_VFETCH;
            end else begin
              walk_step = 1'b1;
              st_d      = S_PFETCH;
            end
          end else if (spent) begin
            fail_ld = 1'b1;
            st_d    = S_FAIL;
          end else begin
            tm_load = 1'b1;
            tm_val  = PULSE_LD;
            st_d    = S_PULSE;
          end
        end
      end
      S_VFETCH: st_d = S_VLOAD;
      S_VLOAD: begin
        byte_ld = 1'b1;
        tm_load = 1'b1;
        tm_val  = SETTLE_LD;
        st_d    = S_VSETTLE;
      end
      S_VSETTLE: begin
        if (tm_exp) begin
          if (!rd_match) begin
            fail_ld = 1'b1;
            st_d    = S_FAIL;
          end else if (at_last) begin
            st_d = S_DONE;
          end else begin
            walk_step = 1'b1;
            st_d      = S_VFETCH;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_ld) begin
      byte_q <= src_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr_q <= '0;
    end else if (fail_ld) begin
      fail_addr_q <= walk_addr;
    end
  end

  // Output decode
  always_comb begin
    tgt_pgm_n   = (st_q != S_PULSE);
    tgt_oe_n    = !((st_q == S_PSETTLE) || (st_q == S_VSETTLE));
    tgt_ce_n    = !((st_q == S_PULSE) || (st_q == S_PSETTLE) || (st_q == S_VSETTLE));
    tgt_dq_oe   = (st_q == S_PULSE);
    vpp_req     = (st_q == S_PFETCH) || (st_q == S_PLOAD) ||
                  (st_q == S_PULSE)  || (st_q == S_PSETTLE);
    vcc_hi_req  = vpp_req;
    nom_chk_req = (st_q == S_VFETCH) || (st_q == S_VLOAD) || (st_q == S_VSETTLE);
    done        = (st_q == S_DONE);
    fail        = (st_q == S_FAIL);
  end

  assign src_addr  = walk_addr;
  assign tgt_addr  = walk_addr;
  assign tgt_dout  = byte_q;
  assign fail_addr = fail_addr_q;

  // R2
  pulse_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_pgm_n |-> (!tgt_ce_n && tgt_oe_n && tgt_dq_oe));

  // R2
  pulse_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_pgm_n && $past(!tgt_pgm_n)) |-> ($stable(tgt_addr) && $stable(tgt_dout)));

  // R7
  pulse_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_pgm_n || (!tgt_oe_n && !nom_chk_req)) |-> (vpp_req && vcc_hi_req));

  // R8
  ff_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_pgm_n |-> (tgt_dout != {DATA_W{1'b1}}));

  // R6
  addr_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_addr != $past(tgt_addr)) && (tgt_addr != '0)) |->
      (tgt_addr == ADDR_W'($past(tgt_addr) + 1'b1)));

  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

// File: tb/eprom_burn_seq_bench.sv
module eprom_burn_seq_bench;

  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int N      = 1 << AW;
  localparam int CLKHZ  = 50_000_000;
  localparam int PUS    = 1;
  localparam int PCYC   = (CLKHZ / 1_000_000) * PUS;
  localparam int MAXP   = 5;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          start;
  logic [AW-1:0] src_addr;
  logic [DW-1:0] src_data;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_dout;
  logic          tgt_dq_oe;
  logic [DW-1:0] tgt_din;
  logic          tgt_ce_n, tgt_oe_n, tgt_pgm_n;
  logic          vpp_req, vcc_hi_req, nom_chk_req;
  logic          done, fail;
  logic [AW-1:0] fail_addr;

  eprom_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(CLKHZ), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .SETTLE_CYC(SETTLE)
  ) u_eprom_burn_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_addr(src_addr), .src_data(src_data),
    .tgt_addr(tgt_addr), .tgt_dout(tgt_dout), .tgt_dq_oe(tgt_dq_oe),
    .tgt_din(tgt_din), .tgt_ce_n(tgt_ce_n), .tgt_oe_n(tgt_oe_n),
    .tgt_pgm_n(tgt_pgm_n), .vpp_req(vpp_req), .vcc_hi_req(vcc_hi_req),
    .nom_chk_req(nom_chk_req), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  // Source memory and behavioural target
  logic [DW-1:0] src_mem [N];
  logic [DW-1:0] tgt_mem [N];
  int            need    [N];
  int            hits    [N];
  int            bad_vaddr;

  always @(posedge clk) src_data <= src_mem[src_addr];

  assign tgt_din = (!tgt_ce_n && !tgt_oe_n) ?
    (tgt_mem[tgt_addr] ^ ((nom_chk_req && int'(tgt_addr) == bad_vaddr) ? 8'h01 : 8'h00)) :
    8'hFF;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct { int a; int d; } pev_t;
  pev_t exp_q[$];
  int   vexp;

  int plen = 0, olen = 0;
  int p_addr, p_data, o_addr;
  bit p_bad, p_sup_bad, o_bad, o_nom, o_sup_bad;

  always @(negedge clk) begin
    if (!rst_n) begin
      plen = 0; olen = 0;
      p_bad = 0; p_sup_bad = 0; o_bad = 0; o_nom = 0; o_sup_bad = 0;
    end else begin
      if (!tgt_pgm_n) begin
        plen++;
        p_addr = int'(tgt_addr);
        p_data = int'(tgt_dout);
        if (tgt_ce_n || !tgt_oe_n || !tgt_dq_oe) p_bad = 1;
        if (!vpp_req || !vcc_hi_req || nom_chk_req) p_sup_bad = 1;
      end else if (plen > 0) begin
        hits[p_addr]++;
        if (hits[p_addr] >= need[p_addr]) tgt_mem[p_addr] = tgt_mem[p_addr] & DW'(p_data);
        chk(plen == PCYC, "R2", "pulse width", plen, PCYC);
        chk(!p_bad, "R2", "pulse strobes", int'(p_bad), 0);
        chk(!p_sup_bad, "R7", "supplies during pulse", int'(p_sup_bad), 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected pulse at address", p_addr, -1);
        end else begin
          pev_t e;
          e = exp_q.pop_front();
          chk(p_addr == e.a, "R6", "pulse address", p_addr, e.a);
          chk(p_data == e.d, "R2", "pulse data", p_data, e.d);
        end
        plen = 0; p_bad = 0; p_sup_bad = 0;
      end
      if (!tgt_oe_n) begin
        olen++;
        o_addr = int'(tgt_addr);
        o_nom  = nom_chk_req;
        if (tgt_ce_n || !tgt_pgm_n || tgt_dq_oe) o_bad = 1;
        if (nom_chk_req && (vpp_req || vcc_hi_req)) o_sup_bad = 1;
        if (!nom_chk_req && (!vpp_req || !vcc_hi_req)) o_sup_bad = 1;
      end else if (olen > 0) begin
        chk(olen == SETTLE, "R3", "readback window length", olen, SETTLE);
        chk(!o_bad, "R3", "readback strobes", int'(o_bad), 0);
        chk(!o_sup_bad, "R7", "supplies during readback", int'(o_sup_bad), 0);
        if (o_nom) begin
          chk(o_addr == vexp, "R9", "final verify address", o_addr, vexp);
          vexp++;
        end
        olen = 0; o_bad = 0; o_sup_bad = 0;
      end
    end
  end

  // Driver: builds expected pulse list and runs one programming pass
  task automatic run_case(input string name, input bit exp_done, input int exp_faddr,
                          input int exp_v);
    int t;
    bit stop;
    pev_t e;
    for (int a = 0; a < N; a++) begin
      tgt_mem[a] = 8'hFF;
      hits[a] = 0;
    end
    vexp = 0;
    exp_q.delete();
    stop = 0;
    for (int a = 0; a < N && !stop; a++) begin
      if (src_mem[a] != 8'hFF) begin
        int k;
        k = (need[a] > MAXP) ? MAXP : need[a];
        for (int i = 0; i < k; i++) begin
          e.a = a; e.d = int'(src_mem[a]);
          exp_q.push_back(e);
        end
        if (need[a] > MAXP) stop = 1;
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!(done || fail) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (40) @(negedge clk);
    $display("case %s finished", name);
    chk(done == exp_done, "R10", "done level", int'(done), int'(exp_done));
    chk(fail == !exp_done, "R5", "fail level", int'(fail), int'(!exp_done));
    if (!exp_done)
      chk(int'(fail_addr) == exp_faddr, "R5", "fail address", int'(fail_addr), exp_faddr);
    chk(exp_q.size() == 0, "R4", "pulses still expected", exp_q.size(), 0);
    chk(vexp == exp_v, "R9", "final verify reads", vexp, exp_v);
    chk(tgt_ce_n && tgt_oe_n && tgt_pgm_n, "R5", "strobes idle after end",
        int'({tgt_ce_n, tgt_oe_n, tgt_pgm_n}), 7);
    if (exp_done) begin
      int bad;
      bad = 0;
      for (int a = 0; a < N; a++) if (tgt_mem[a] != src_mem[a]) bad++;
      chk(bad == 0, "R4", "target bytes differing from source", bad, 0);
    end
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    bad_vaddr = -1;
    for (int a = 0; a < N; a++) begin
      src_mem[a] = 8'hFF; tgt_mem[a] = 8'hFF; need[a] = 1; hits[a] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(tgt_ce_n && tgt_oe_n && tgt_pgm_n, "R1", "strobes in reset",
        int'({tgt_ce_n, tgt_oe_n, tgt_pgm_n}), 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tgt_ce_n && tgt_oe_n && tgt_pgm_n && !tgt_dq_oe, "R1", "strobes after reset",
        int'({tgt_ce_n, tgt_oe_n, tgt_pgm_n, tgt_dq_oe}), 14);
    chk(!vpp_req && !vcc_hi_req && !nom_chk_req, "R1", "supply requests after reset",
        int'({vpp_req, vcc_hi_req, nom_chk_req}), 0);
    chk(!done && !fail, "R1", "status after reset", int'({done, fail}), 0);

    // Mixed image with FFh gaps, 1..3 pulses needed (R4, R6, R8)
    for (int a = 0; a < N; a++) begin
      src_mem[a] = ((a % 4) == 3) ? 8'hFF : (DW'(a * 17) ^ 8'h5A);
      need[a]    = 1 + (a % 3);
    end
    run_case("mixed", 1'b1, 0, N);
    begin
      int sk;
      sk = 0;
      for (int a = 0; a < N; a++) if (src_mem[a] == 8'hFF && hits[a] != 0) sk++;
      chk(sk == 0, "R8", "FFh addresses that were pulsed", sk, 0);
    end

    // All erased image: no pulses, restart from done (R10)
    for (int a = 0; a < N; a++) src_mem[a] = 8'hFF;
    run_case("all_ff", 1'b1, 0, N);

    // Address needing exactly the limit still passes (R4)
    for (int a = 0; a < N; a++) begin
      src_mem[a] = DW'(a * 17) ^ 8'h5A;
      need[a]    = 1;
    end
    need[5] = MAXP;
    run_case("at_limit", 1'b1, 0, N);

    // Address that never programs: exhaustion (R5)
    need[5] = 1;
    need[6] = MAXP + 2;
    run_case("stubborn", 1'b0, 6, 0);

    // Final verify mismatch under nominal supplies (R9), restart from fail (R10)
    need[6] = 1;
    bad_vaddr = 9;
    run_case("verify_miss", 1'b0, 9, 10);
    bad_vaddr = -1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule